// File: doc/BRIEF.md
# Serial Port Control Register Block

This block is the byte-wide register front end of a simple serial port. A host reaches it over a single-cycle synchronous bus with chip select, write strobe, a 6-bit address and 8-bit data. Behind that bus sit two mode registers that share one address through a self-advancing pointer, plus a status view, a packed command register, a transmit holding byte, an interrupt status/mask pair and two read-only baud divider bytes. The baud divider values come in as inputs.

The block holds the transmitter and receiver enable states. A byte written to the transmit address waits in the holding stage until it is taken on a valid/ready byte stream. The receive FIFO storage lives outside the block. The block sees the FIFO's fill count and head byte. It drives a pop strobe when the host reads received data, a flush strobe when the receiver is reset, and the receiver enable level. One level-sensitive interrupt output combines the masked interrupt sources.

Top module: `uart_csr`

## Requirements
- R1: After reset, status reads 0x08 (only the transmit-empty flag), the mode registers, interrupt status and mask all read 0, both enables are off, tx_valid_o and irq_o are low.
- R2: A read with cs_i high and we_i low presents its data on rdata_o from the next cycle on, and rdata_o holds until the next read. The offsets (address taken as 6 bits) are: 0x00 mode, 0x04 status, 0x0C received data, 0x14 interrupt status, 0x18 baud byte A, 0x1C baud byte B. Every other offset reads 0, including the write-only 0x08. Writes to offsets other than 0x00, 0x08, 0x0C and 0x14 change nothing.
- R3: Offset 0x00 holds two mode registers selected by a pointer that is 0 after reset. A write stores into the selected register and then sets the pointer to 1, where it stays. A read returns the selected register.
- R4: In the command byte written to 0x08, bits 3:2 control the transmitter and bits 1:0 the receiver. Code 1 enables, code 2 disables and code 3 has no effect. rx_en_o shows the receiver enable. These fields take effect after the miscellaneous field of the same byte.
- R5: Command bits 6:4 are the miscellaneous field. Code 1 returns the mode pointer to 0. Code 2 disables the receiver. Code 3 disables the transmitter and discards any held byte. Code 5 clears the break-change flag. Codes 0, 4, 6 and 7 do nothing.
- R6: The status byte is {4'b0, TxEMP, TxRDY, FFULL, RxRDY}. RxRDY is set when rx_count_i is nonzero. FFULL is set when rx_count_i equals FIFO_DEPTH. TxRDY equals the transmitter enable. TxEMP is set when no byte is held.
- R7: A write to 0x0C loads the holding byte and clears TxEMP. While a byte is held and the transmitter is enabled, tx_valid_o is high with the byte on tx_data_o. TxEMP returns the cycle after tx_valid_o and tx_ready_i are both high. While the transmitter is disabled, the byte stays held.
- R8: A read of 0x0C with rx_count_i nonzero returns rx_data_i and pulses rx_pop_o in that cycle. With rx_count_i zero, the read returns 0 and rx_pop_o stays low.
- R9: Interrupt status is {5'b0, BRK, RxINT, TxINT}. TxINT equals TxRDY. RxINT equals FFULL when bit 6 of the first mode register is set, and RxRDY otherwise.
- R10: A brk_i pulse sets BRK (bit 2), which stays set until a miscellaneous code 5 command. When both occur in the same cycle, the set wins.
- R11: irq_o is high when any bit of the interrupt status ANDed with the mask (written at 0x14) is set.
- R12: rx_flush_o pulses in the cycle of a command write whose miscellaneous field is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus select |
| we_i | input | 1 | Write strobe (1 write, 0 read) |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_data_i | input | 8 | Receive FIFO head byte |
| rx_pop_o | output | 1 | Pop one byte from the receive FIFO |
| rx_flush_o | output | 1 | Empty the receive FIFO |
| rx_en_o | output | 1 | Receiver enabled |
| brk_i | input | 1 | Break-change event pulse |
| baud_a_i | input | 8 | Baud divider byte A |
| baud_b_i | input | 8 | Baud divider byte B |
| tx_data_o | output | 8 | Transmit byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmit sink ready |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions take for granted that the external FIFO keeps rx_count_i within 0..FIFO_DEPTH. They also assume it applies a pop or flush before the next clock, and that rx_data_i is the head byte whenever the count is nonzero. The bench keeps its FIFO as a queue that behaves this way: it pushes only when there is room and updates the count one cycle after each pop or flush. Everything else is driven freely, including reserved command codes and random ready and break patterns.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int ADDR_W = 6;
  localparam int MODE_N = 2;

  localparam logic [ADDR_W-1:0] OFS_MODE   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD    = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_IRQ    = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_BAUD_A = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_BAUD_B = 6'h1C;

  localparam logic [2:0] MISC_PTR_RST = 3'd1;
  localparam logic [2:0] MISC_RX_RST  = 3'd2;
  localparam logic [2:0] MISC_TX_RST  = 3'd3;
  localparam logic [2:0] MISC_BRK_CLR = 3'd5;
  localparam logic [1:0] PATH_ON      = 2'd1;
  localparam logic [1:0] PATH_OFF     = 2'd2;

  localparam int MODE_RXSEL_BIT = 6;

  typedef struct packed {
    logic ptr_rst;
    logic rx_reset;
    logic tx_reset;
    logic brk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_t;
endpackage

// File: rtl/uart_csr_cmd.sv
module uart_csr_cmd
  import uart_csr_pkg::*;
(
  input  logic       strobe_i,
  input  logic [6:0] cmd_i,
  output cmd_t       ctl_o
);
  logic [2:0] misc;
  logic [1:0] txf, rxf;

  assign misc = cmd_i[6:4];
  assign txf  = cmd_i[3:2];
  assign rxf  = cmd_i[1:0];

  always_comb begin
    ctl_o          = '0;
    ctl_o.ptr_rst  = strobe_i && (misc == MISC_PTR_RST);
    ctl_o.rx_reset = strobe_i && (misc == MISC_RX_RST);
    ctl_o.tx_reset = strobe_i && (misc == MISC_TX_RST);
    ctl_o.brk_clr  = strobe_i && (misc == MISC_BRK_CLR);
    ctl_o.tx_on    = strobe_i && (txf == PATH_ON);
    ctl_o.tx_off   = strobe_i && (txf == PATH_OFF);
    ctl_o.rx_on    = strobe_i && (rxf == PATH_ON);
    ctl_o.rx_off   = strobe_i && (rxf == PATH_OFF);
  end
endmodule

// File: rtl/uart_csr_tx.sv
module uart_csr_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              reset_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  logic              held_q;
  logic [DATA_W-1:0] byte_q;

  assign valid_o = held_q && en_i;
  assign data_o  = byte_q;
  assign empty_o = !held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      byte_q <= '0;
    end else begin
      if (wr_i) byte_q <= wdata_i;
      if (reset_i)                  held_q <= 1'b0;
      else if (wr_i)                held_q <= 1'b1;
      else if (valid_o && ready_i)  held_q <= 1'b0;
    end
  end

  // R7
  tx_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !wr_i) |=> empty_o);
  // R7
  tx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !reset_i) |=> (!empty_o && data_o == $past(wdata_i)));
endmodule

// File: rtl/uart_csr_irq.sv
module uart_csr_irq #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_rdy_i,
  input  logic              rx_rdy_i,
  input  logic              rx_full_i,
  input  logic              sel_full_i,
  input  logic              brk_i,
  input  logic              brk_clr_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] isr_o,
  output logic              irq_o
);
  logic              brk_q;
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (brk_i)          brk_q <= 1'b1;
      else if (brk_clr_i) brk_q <= 1'b0;
      if (mask_wr_i) mask_q <= wdata_i;
    end
  end

  always_comb begin
    isr_o    = '0;
    isr_o[0] = tx_rdy_i;
    isr_o[1] = sel_full_i ? rx_full_i : rx_rdy_i;
    isr_o[2] = brk_q;
  end

  assign irq_o = |(isr_o & mask_q);

  // R10
  brk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> isr_o[2]);
  // R11
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && wdata_i == '0) |=> !irq_o);
endmodule

// File: rtl/uart_csr.sv
module uart_csr
  import uart_csr_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int DATA_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_pop_o,
  output logic              rx_flush_o,
  output logic              rx_en_o,
  input  logic              brk_i,
  input  logic [DATA_W-1:0] baud_a_i,
  input  logic [DATA_W-1:0] baud_b_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  logic wr, rd, wr_mode, wr_cmd, wr_data, wr_mask;
  cmd_t ctl;
  logic [DATA_W-1:0] mode_q [MODE_N];
  logic              mode_ptr_q;
  logic              tx_en_q, rx_en_q;
  logic              rx_rdy, rx_full, tx_empty;
  logic [DATA_W-1:0] status, isr, rd_mux, rdata_q;

  assign wr      = cs_i && we_i;
  assign rd      = cs_i && !we_i;
  assign wr_mode = wr && (addr_i == OFS_MODE);
  assign wr_cmd  = wr && (addr_i == OFS_CMD);
  assign wr_data = wr && (addr_i == OFS_DATA);
  assign wr_mask = wr && (addr_i == OFS_IRQ);

  uart_csr_cmd u_cmd (
    .strobe_i (wr_cmd),
    .cmd_i    (wdata_i[6:0]),
    .ctl_o    (ctl)
  );

  for (genvar i = 0; i < MODE_N; i++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mode_q[i] <= '0;
      else if (wr_mode && (mode_ptr_q == 1'(i)))  mode_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_ptr_q <= 1'b0;
      tx_en_q    <= 1'b0;
      rx_en_q    <= 1'b0;
    end else begin
      if (ctl.ptr_rst)  mode_ptr_q <= 1'b0;
      else if (wr_mode) mode_ptr_q <= 1'b1;
      // path fields act after the misc field of the same byte
      if (ctl.tx_on)                      tx_en_q <= 1'b1;
      else if (ctl.tx_off || ctl.tx_reset) tx_en_q <= 1'b0;
      if (ctl.rx_on)                      rx_en_q <= 1'b1;
      else if (ctl.rx_off || ctl.rx_reset) rx_en_q <= 1'b0;
    end
  end

  assign rx_rdy  = rx_count_i != '0;
  assign rx_full = rx_count_i == CNT_W'(FIFO_DEPTH);

  uart_csr_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_data),
    .wdata_i (wdata_i),
    .en_i    (tx_en_q),
    .reset_i (ctl.tx_reset),
    .ready_i (tx_ready_i),
    .valid_o (tx_valid_o),
    .data_o  (tx_data_o),
    .empty_o (tx_empty)
  );

  uart_csr_irq #(.DATA_W(DATA_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_rdy_i   (tx_en_q),
    .rx_rdy_i   (rx_rdy),
    .rx_full_i  (rx_full),
    .sel_full_i (mode_q[0][MODE_RXSEL_BIT]),
    .brk_i      (brk_i),
    .brk_clr_i  (ctl.brk_clr),
    .mask_wr_i  (wr_mask),
    .wdata_i    (wdata_i),
    .isr_o      (isr),
    .irq_o      (irq_o)
  );

  always_comb begin
    status    = '0;
    status[0] = rx_rdy;
    status[1] = rx_full;
    status[2] = tx_en_q;
    status[3] = tx_empty;
  end

  always_comb begin
    unique case (addr_i)
      OFS_MODE:   rd_mux = mode_q[mode_ptr_q];
      OFS_STAT:   rd_mux = status;
      OFS_DATA:   rd_mux = rx_rdy ? rx_data_i : '0;
      OFS_IRQ:    rd_mux = isr;
      OFS_BAUD_A: rd_mux = baud_a_i;
      OFS_BAUD_B: rd_mux = baud_b_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o    = rdata_q;
  assign rx_pop_o   = rd && (addr_i == OFS_DATA) && rx_rdy;
  assign rx_flush_o = ctl.rx_reset;
  assign rx_en_o    = rx_en_q;

  // R3
  mode_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> mode_ptr_q);
  // R4
  tx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_CMD && wdata_i[3:2] == PATH_OFF) |=> !tx_valid_o);
  // R8
  pop_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFS_DATA && rx_count_i == '0) |=> rdata_o == '0);
endmodule

// File: tb/uart_csr_bench.sv
module uart_csr_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          cs_i = 0, we_i = 0, tx_ready_i = 0, brk_i = 0;
  logic [5:0]    addr_i = '0;
  logic [7:0]    wdata_i = '0, rx_data_i = '0;
  logic [CW-1:0] rx_count_i = '0;
  logic [7:0]    baud_a_i = 8'h3A, baud_b_i = 8'hC5;
  logic [7:0]    rdata_o, tx_data_o;
  logic          rx_pop_o, rx_flush_o, rx_en_o, tx_valid_o, irq_o;

  uart_csr #(.FIFO_DEPTH(DEPTH)) u_uart_csr (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rx_count_i(rx_count_i),
    .rx_data_i(rx_data_i), .rx_pop_o(rx_pop_o), .rx_flush_o(rx_flush_o),
    .rx_en_o(rx_en_o), .brk_i(brk_i), .baud_a_i(baud_a_i), .baud_b_i(baud_b_i),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .irq_o(irq_o)
  );

  // behavioural reference state
  logic [7:0] m_mr [2];
  bit         m_ptr, m_txen, m_rxen, m_held, m_brk;
  logic [7:0] m_tb, m_imr, m_rd;
  logic [7:0] fifo [$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {4'b0, !m_held, m_txen, fifo.size() == DEPTH, fifo.size() != 0};
  endfunction

  function automatic logic [7:0] m_isr();
    bit rxint = m_mr[0][6] ? (fifo.size() == DEPTH) : (fifo.size() != 0);
    return {5'b0, m_brk, rxint, m_txen};
  endfunction

  function automatic logic [7:0] m_read(logic [5:0] a);
    case (a)
      6'h00: return m_mr[m_ptr];
      6'h04: return m_status();
      6'h0C: return fifo.size() != 0 ? fifo[0] : 8'h00;
      6'h14: return m_isr();
      6'h18: return baud_a_i;
      6'h1C: return baud_b_i;
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(bit cs, bit we, logic [5:0] a, logic [7:0] d,
                      bit rdy, bit brk, bit push, logic [7:0] pdat);
    bit e_pop, e_flush, e_valid, e_irq, hs;
    logic [2:0] misc;
    logic [1:0] txf, rxf;
    @(negedge clk);
    if (push && fifo.size() < DEPTH) fifo.push_back(pdat);
    cs_i = cs; we_i = we; addr_i = a; wdata_i = d;
    tx_ready_i = rdy; brk_i = brk;
    rx_count_i = CW'(fifo.size());
    rx_data_i  = fifo.size() != 0 ? fifo[0] : 8'h00;
    #1;
    misc = d[6:4]; txf = d[3:2]; rxf = d[1:0];
    e_pop   = cs && !we && a == 6'h0C && fifo.size() != 0;
    e_flush = cs && we && a == 6'h08 && misc == 3'd2;
    e_valid = m_held && m_txen;
    e_irq   = |(m_isr() & m_imr);
    chk(rdata_o == m_rd, "R2 rdata", rdata_o, m_rd);
    chk(tx_valid_o == e_valid, "R7 tx_valid", 8'(tx_valid_o), 8'(e_valid));
    if (e_valid) chk(tx_data_o == m_tb, "R7 tx_data", tx_data_o, m_tb);
    chk(irq_o == e_irq, "R11 irq", 8'(irq_o), 8'(e_irq));
    chk(rx_pop_o == e_pop, "R8 pop", 8'(rx_pop_o), 8'(e_pop));
    chk(rx_flush_o == e_flush, "R12 flush", 8'(rx_flush_o), 8'(e_flush));
    chk(rx_en_o == m_rxen, "R4 rx_en", 8'(rx_en_o), 8'(m_rxen));
    // next state, consumed by the design at the coming edge
    hs = m_held && m_txen && rdy;
    if (cs && !we) m_rd = m_read(a);
    if (cs && we && a == 6'h00) begin m_mr[m_ptr] = d; m_ptr = 1; end
    if (cs && we && a == 6'h14) m_imr = d;
    if (cs && we && a == 6'h0C) m_tb = d;
    if (cs && we && a == 6'h08 && misc == 3'd3) m_held = 0;
    else if (cs && we && a == 6'h0C) m_held = 1;
    else if (hs) m_held = 0;
    if (cs && we && a == 6'h08) begin
      if (misc == 3'd1) m_ptr = 0;
      if (misc == 3'd2) m_rxen = 0;
      if (misc == 3'd3) m_txen = 0;
      if (misc == 3'd5) m_brk = 0;
      if (txf == 2'd1) m_txen = 1; else if (txf == 2'd2) m_txen = 0;
      if (rxf == 2'd1) m_rxen = 1; else if (rxf == 2'd2) m_rxen = 0;
    end
    if (brk) m_brk = 1;
    if (e_pop) void'(fifo.pop_front());
    if (e_flush) fifo.delete();
  endtask

  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) step(0, 0, 6'h00, 8'h00, 0, 0, 0, 8'h00);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    step(1, 1, a, d, 0, 0, 0, 8'h00);
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] exp, string tag);
    step(1, 0, a, 8'h00, 0, 0, 0, 8'h00);
    idle();
    chk(rdata_o == exp, tag, rdata_o, exp);
  endtask

  task automatic push(logic [7:0] b);
    step(0, 0, 6'h00, 8'h00, 0, 0, 1, b);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_mr[0] = 0; m_mr[1] = 0; m_ptr = 0; m_txen = 0; m_rxen = 0;
    m_held = 0; m_brk = 0; m_tb = 0; m_imr = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle(2);
    // R1 reset state
    chk(tx_valid_o == 0 && irq_o == 0, "R1 outputs", {tx_valid_o, irq_o}, 8'h00);
    rd(6'h04, 8'h08, "R1 status");
    rd(6'h14, 8'h00, "R1 isr");
    rd(6'h00, 8'h00, "R1 mode");
    // R3 mode pointer
    wr(6'h00, 8'hA5);
    wr(6'h00, 8'h3C);
    rd(6'h00, 8'h3C, "R3 second mode");
    wr(6'h00, 8'h77);
    rd(6'h00, 8'h77, "R3 pointer stays");
    wr(6'h08, 8'h10);
    rd(6'h00, 8'hA5, "R3 R5 pointer reset");
    // R2 decode, unmapped and write-only offsets
    rd(6'h18, 8'h3A, "R2 baud A");
    rd(6'h1C, 8'hC5, "R2 baud B");
    rd(6'h08, 8'h00, "R2 cmd reads 0");
    rd(6'h20, 8'h00, "R2 unmapped");
    wr(6'h04, 8'hFF); wr(6'h10, 8'hFF); wr(6'h3C, 8'hFF);
    rd(6'h04, 8'h08, "R2 ignored writes");
    idle(3);
    chk(rdata_o == 8'h08, "R2 rdata holds", rdata_o, 8'h08);
    // R6 R9 R11 transmitter enable
    wr(6'h14, 8'hFF);
    wr(6'h08, 8'h04);
    rd(6'h04, 8'h0C, "R6 tx ready");
    rd(6'h14, 8'h01, "R9 txint");
    chk(irq_o == 1, "R11 irq on", 8'(irq_o), 8'h01);
    // R4 reserved tx code
    wr(6'h08, 8'h0C);
    rd(6'h04, 8'h0C, "R4 reserved tx");
    // R7 handshake
    wr(6'h0C, 8'h5A);
    idle(3);
    chk(tx_valid_o == 1 && tx_data_o == 8'h5A, "R7 hold", tx_data_o, 8'h5A);
    rd(6'h04, 8'h04, "R7 txemp clear");
    step(0, 0, 6'h00, 8'h00, 1, 0, 0, 8'h00);
    idle();
    chk(tx_valid_o == 0, "R7 sent", 8'(tx_valid_o), 8'h00);
    rd(6'h04, 8'h0C, "R7 txemp set");
    // R7 disabled transmitter holds byte
    wr(6'h08, 8'h08);
    wr(6'h0C, 8'hC3);
    step(0, 0, 6'h00, 8'h00, 1, 0, 0, 8'h00);
    rd(6'h04, 8'h00, "R7 held while off");
    wr(6'h08, 8'h04);
    step(0, 0, 6'h00, 8'h00, 1, 0, 0, 8'h00);
    rd(6'h04, 8'h0C, "R7 sent after enable");
    // R5 misc 3 discards byte
    wr(6'h08, 8'h08);
    wr(6'h0C, 8'h99);
    wr(6'h08, 8'h30);
    rd(6'h04, 8'h08, "R5 tx reset");
    // R8 R6 R9 receive path
    wr(6'h08, 8'h01);
    rd(6'h0C, 8'h00, "R8 empty read");
    push(8'h11); push(8'h22);
    rd(6'h04, 8'h09, "R6 rxrdy");
    rd(6'h14, 8'h02, "R9 rxint from rxrdy");
    rd(6'h0C, 8'h11, "R8 head byte");
    push(8'h33); push(8'h44); push(8'h55);
    rd(6'h04, 8'h0B, "R6 ffull");
    wr(6'h08, 8'h10);
    wr(6'h00, 8'hE5);
    rd(6'h14, 8'h02, "R9 rxint from ffull");
    rd(6'h0C, 8'h22, "R8 second byte");
    rd(6'h14, 8'h00, "R9 not full");
    // R10 break flag
    step(0, 0, 6'h00, 8'h00, 0, 1, 0, 8'h00);
    rd(6'h14, 8'h04, "R10 set");
    wr(6'h08, 8'h40);
    rd(6'h14, 8'h04, "R10 misc4 no-op");
    step(1, 1, 6'h08, 8'h50, 0, 1, 0, 8'h00);
    rd(6'h14, 8'h04, "R10 set wins");
    wr(6'h08, 8'h50);
    rd(6'h14, 8'h00, "R10 cleared");
    // R12 flush
    wr(6'h08, 8'h20);
    idle();
    chk(rx_en_o == 0, "R12 rx off", 8'(rx_en_o), 8'h00);
    rd(6'h04, 8'h08, "R12 flushed");
    // R11 mask
    wr(6'h08, 8'h04);
    wr(6'h14, 8'h00);
    idle();
    chk(irq_o == 0, "R11 masked", 8'(irq_o), 8'h00);
    // random traffic against the model
    for (int i = 0; i < 1500; i++) begin
      logic [5:0] a;
      int sel = int'($urandom_range(0, 7));
      case (sel)
        0: a = 6'h00; 1: a = 6'h04; 2: a = 6'h08; 3: a = 6'h0C;
        4: a = 6'h14; 5: a = 6'h18; 6: a = 6'h1C; default: a = 6'(2 * $urandom_range(0, 31));
      endcase
      step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a,
           8'($urandom), $urandom_range(0, 2) != 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 2) == 0, 8'($urandom));
    end
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule